// File: doc/BRIEF.md
# Fault Flag Collector with Open-Drain Alert

This block gathers seven fault detectors into one sticky flag vector that software reads and that clears itself on the read. Six of the detectors arrive from elsewhere on the chip as level or single-cycle pulse inputs. The seventh, a serial-frame length check, lives inside the block. It watches the chip-select and serial-clock lines of the SPI port and counts clock rising edges while select is low. When select goes high, it judges whether the frame held a whole number of 16-bit words. All inputs are taken as synchronous to `clk`.

A per-source enable mask decides which flags may pull the shared alert line low. The alert is modelled as an output-enable: 1 means drive the pin low, 0 means release it. A mode input selects between two behaviours. In latched mode the alert follows the sticky flags. In dynamic mode it follows the registered live fault conditions, so it drops as soon as a fault goes away, even while its flag is still set.

The frame checker is a three-state machine. SPI_IDLE moves to SPI_SHIFT on a select falling edge, which also clears the bit counter. SPI_SHIFT counts clock rising edges and moves to SPI_CHECK when select is seen high. SPI_CHECK lasts one cycle and issues the verdict. It then returns to SPI_IDLE, or goes straight back to SPI_SHIFT if select falls again. The alert driver has two states. AL_RELEASED moves to AL_DRIVEN when the request for the selected mode is active. AL_DRIVEN moves back to AL_RELEASED when that request is inactive.

Top module: `fault_alert_top`

## Requirements
- R1: The flag vector is 8 bits wide. Bit 0 is reserved and always reads 0. Bit 1 is the ADC self-check, bit 2 the inrush limiter, bit 3 the serial-frame error, bit 4 the data-stream loss, bit 5 the CRC error, bit 6 the FET failure and bit 7 the memory error. `det_src` and `alert_en` use the same bit positions. Bits 0 and 3 of `det_src` are ignored.
- R2: A detect seen in cycle t sets its flag from cycle t+1 onward. The flag stays set until a read, whether or not that source is enabled in `alert_en`.
- R3: A cycle with `flag_rd` high shows the flags as they were before the clear. Every flag with no active detect in that cycle is 0 from the next cycle.
- R4: A detect that is active in the same cycle as `flag_rd` wins over the clear. That flag is still set in the next cycle, whether the fault is persistent or new.
- R5: `alert_oe` stays 0 when no source enabled in `alert_en` has a set flag (latched mode) or an active condition (dynamic mode).
- R6: With `dyn_mode` = 0, `alert_oe` is 1 in cycle t+1 whenever an enabled flag is set in cycle t. It returns to 0 one cycle after the last enabled flag clears.
- R7: With `dyn_mode` = 1, `alert_oe` is 1 two cycles after an enabled detect is active. It returns to 0 two cycles after that detect ends, even though the flag stays set.
- R8: Each `spi_sclk` rising edge seen while in a frame counts one bit. If `spi_cs_n` is seen high in cycle e and the count is not a multiple of 16, `frame_err` pulses for one cycle in e+1 and flag bit 3 sets in e+2.
- R9: A frame whose count is a multiple of 16, including zero, gives a one-cycle `frame_ok` pulse in e+1 and no flag. A bad frame never gives `frame_ok`, so it is never decoded.
- R10: The bit count restarts at every `spi_cs_n` falling edge. Clock edges seen while select is high are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_src | input | 8 | Fault detect inputs in flag bit positions (bits 0 and 3 ignored) |
| alert_en | input | 8 | Per-source alert enable mask |
| dyn_mode | input | 1 | 0 = latched alert, 1 = dynamic alert |
| flag_rd | input | 1 | Flag read strobe, clears the flags |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sclk | input | 1 | Serial clock |
| flags | output | 8 | Sticky flag vector |
| frame_ok | output | 1 | One-cycle pulse: frame length valid, may be decoded |
| frame_err | output | 1 | One-cycle pulse: frame length invalid |
| alert_oe | output | 1 | 1 = drive alert line low, 0 = release |

## Verification
A read strobe and a fresh fault detection can fall in the same clock cycle, and the flag bank must let the set win. The bench provokes this by holding one source continuously, pulsing a second source only in the read cycle, and asserting `flag_rd` in that cycle. In the next cycle it expects both bits set and the enabled alert still driven. It then confirms that a later read, with nothing active, clears everything.

// File: rtl/fault_alert_pkg.sv
package fault_alert_pkg;

    localparam int FLAG_W     = 8;
    localparam int IDX_RSVD   = 0;
    localparam int IDX_ADC    = 1;
    localparam int IDX_INRUSH = 2;
    localparam int IDX_FRAME  = 3;
    localparam int IDX_STREAM = 4;
    localparam int IDX_CRC    = 5;
    localparam int IDX_FET    = 6;
    localparam int IDX_MEM    = 7;

    // external detect bits that are honoured (reserved and frame bits come from elsewhere)
    localparam logic [FLAG_W-1:0] EXT_MASK =
        ~((FLAG_W'(1) << IDX_RSVD) | (FLAG_W'(1) << IDX_FRAME));

    typedef enum logic [1:0] {
        SPI_IDLE  = 2'd0,
        SPI_SHIFT = 2'd1,
        SPI_CHECK = 2'd2
    } spi_state_e;

    typedef enum logic {
        AL_RELEASED = 1'b0,
        AL_DRIVEN   = 1'b1
    } alert_state_e;

endpackage

// File: rtl/spi_frame_checker.sv
module spi_frame_checker
    import fault_alert_pkg::*;
#(
    parameter int FRAME_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    output logic frame_ok,
    output logic frame_err
);

    localparam int CNT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;

    spi_state_e       state_q, state_d;
    logic             cs_prev_q, sclk_prev_q;
    logic [CNT_W-1:0] bit_cnt_q, bit_cnt_d;
    logic             cs_fall, sclk_rise;

    assign cs_fall   = cs_prev_q & ~cs_n;
    assign sclk_rise = sclk & ~sclk_prev_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= SPI_IDLE;
            cs_prev_q   <= 1'b1;
            sclk_prev_q <= 1'b0;
            bit_cnt_q   <= '0;
        end else begin
            state_q     <= state_d;
            cs_prev_q   <= cs_n;
            sclk_prev_q <= sclk;
            bit_cnt_q   <= bit_cnt_d;
        end
    end

    // next state and counter
    always_comb begin
        state_d   = state_q;
        bit_cnt_d = bit_cnt_q;
        unique case (state_q)
            SPI_IDLE: begin
                if (cs_fall) state_d = SPI_SHIFT;
            end
            SPI_SHIFT: begin
                if (cs_n) state_d = SPI_CHECK;
            end
            SPI_CHECK: begin
                state_d = cs_fall ? SPI_SHIFT : SPI_IDLE;
            end
            default: state_d = SPI_IDLE;
        endcase
        if (state_d == SPI_SHIFT && state_q != SPI_SHIFT) begin
            bit_cnt_d = '0;
        end else if (state_q == SPI_SHIFT && !cs_n && sclk_rise) begin
            bit_cnt_d = bit_cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        frame_ok  = 1'b0;
        frame_err = 1'b0;
        unique case (state_q)
            SPI_CHECK: begin
                frame_ok  = (bit_cnt_q == '0);
                frame_err = (bit_cnt_q != '0);
            end
            default: begin
                frame_ok  = 1'b0;
                frame_err = 1'b0;
            end
        endcase
    end

    // R8: the two verdicts never coincide
    a_r8_verdict_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_ok && frame_err));

    // R8: a verdict lasts exactly one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok || frame_err) |=> !(frame_ok || frame_err));

    // R9: a verdict only follows a cycle with select high
    a_r9_after_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok || frame_err) |-> $past(cs_n));

    // R10: a select falling edge in idle always leads to a cleared count
    a_r10_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SPI_IDLE && cs_fall) |=> (bit_cnt_q == '0));

endmodule

// File: rtl/fault_flag_bank.sv
module fault_flag_bank
    import fault_alert_pkg::*;
#(
    parameter int WIDTH = FLAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] det_vec,
    input  logic             rd_clr,
    output logic [WIDTH-1:0] flags,
    output logic [WIDTH-1:0] live
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else begin
                // a detect in the read cycle wins over the clear
                bit_q <= (bit_q & ~rd_clr) | det_vec[i];
            end
        end
        assign flags[i] = bit_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live <= '0;
        end else begin
            live <= det_vec;
        end
    end

    // R2: without a read no flag falls
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((flags & $past(flags)) == $past(flags)));

    // R4: every active detect is visible in the next cycle
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|det_vec) |=> ((flags & $past(det_vec)) == $past(det_vec)));

    // R3: after a read only the detects of the read cycle survive
    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> ((flags & ~$past(det_vec)) == '0));

endmodule

// File: rtl/alert_ctrl.sv
module alert_ctrl
    import fault_alert_pkg::*;
#(
    parameter int WIDTH = FLAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] flags,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] enable,
    input  logic             dyn_mode,
    output logic             alert_oe
);

    alert_state_e state_q, state_d;
    logic         request;

    assign request = dyn_mode ? (|(live & enable)) : (|(flags & enable));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AL_RELEASED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AL_RELEASED: if (request)  state_d = AL_DRIVEN;
            AL_DRIVEN:   if (!request) state_d = AL_RELEASED;
            default:     state_d = AL_RELEASED;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            AL_DRIVEN: alert_oe = 1'b1;
            default:   alert_oe = 1'b0;
        endcase
    end

    // R5: nothing enabled, nothing driven
    a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (((flags | live) & enable) == '0) |=> !alert_oe);

    // R6: latched mode keeps driving while an enabled flag is set
    a_r6_latched_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!dyn_mode && (|(flags & enable))) |=> alert_oe);

    // R7: dynamic mode releases once the live condition is gone
    a_r7_dynamic_release: assert property (@(posedge clk) disable iff (!rst_n)
        (dyn_mode && ((live & enable) == '0)) |=> !alert_oe);

endmodule

// File: rtl/fault_alert_top.sv
module fault_alert_top
    import fault_alert_pkg::*;
#(
    parameter int FRAME_BITS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] det_src,
    input  logic [FLAG_W-1:0] alert_en,
    input  logic              dyn_mode,
    input  logic              flag_rd,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    output logic [FLAG_W-1:0] flags,
    output logic              frame_ok,
    output logic              frame_err,
    output logic              alert_oe
);

    logic [FLAG_W-1:0] det_vec;
    logic [FLAG_W-1:0] live;

    spi_frame_checker #(
        .FRAME_BITS(FRAME_BITS)
    ) frame_chk_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (spi_cs_n),
        .sclk     (spi_sclk),
        .frame_ok (frame_ok),
        .frame_err(frame_err)
    );

    assign det_vec = (det_src & EXT_MASK) | (FLAG_W'(frame_err) << IDX_FRAME);

    fault_flag_bank #(
        .WIDTH(FLAG_W)
    ) flag_bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .det_vec(det_vec),
        .rd_clr (flag_rd),
        .flags  (flags),
        .live   (live)
    );

    alert_ctrl #(
        .WIDTH(FLAG_W)
    ) alert_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags   (flags),
        .live    (live),
        .enable  (alert_en),
        .dyn_mode(dyn_mode),
        .alert_oe(alert_oe)
    );

    // R1: reserved bit never sets
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flags[IDX_RSVD] == 1'b0);

    // R8: a bad frame lands in its flag bit one cycle later
    a_r8_frame_flag: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> flags[IDX_FRAME]);

endmodule

// File: tb/fault_alert_top_tb_top.sv
module fault_alert_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] det_src = '0;
    logic [7:0] alert_en = '0;
    logic       dyn_mode = 1'b0;
    logic       flag_rd = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_sclk = 1'b0;
    logic [7:0] flags;
    logic       frame_ok, frame_err, alert_oe;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int         at;
        bit         is_frame;
        logic [7:0] f;
        logic       a;
        logic       ok;
        logic       err;
        string      req;
    } exp_t;

    exp_t q[$];

    fault_alert_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .det_src  (det_src),
        .alert_en (alert_en),
        .dyn_mode (dyn_mode),
        .flag_rd  (flag_rd),
        .spi_cs_n (spi_cs_n),
        .spi_sclk (spi_sclk),
        .flags    (flags),
        .frame_ok (frame_ok),
        .frame_err(frame_err),
        .alert_oe (alert_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare every expectation due in this cycle
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].at == cyc) begin
                checks++;
                if (q[i].is_frame) begin
                    if (frame_ok !== q[i].ok || frame_err !== q[i].err) begin
                        errors++;
                        $display("FAIL %s cycle %0d: ok/err=%b%b expected %b%b",
                                 q[i].req, cyc, frame_ok, frame_err, q[i].ok, q[i].err);
                    end
                end else begin
                    if (flags !== q[i].f || alert_oe !== q[i].a) begin
                        errors++;
                        $display("FAIL %s cycle %0d: flags=%h alert=%b expected flags=%h alert=%b",
                                 q[i].req, cyc, flags, alert_oe, q[i].f, q[i].a);
                    end
                end
                q.delete(i);
            end else if (q[i].at < cyc) begin
                errors++;
                $display("FAIL %s: expectation for cycle %0d missed (actual n/a, expected sample)",
                         q[i].req, q[i].at);
                q.delete(i);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push_fa(int at, logic [7:0] f, logic a, string req);
        exp_t e;
        e.at = at; e.is_frame = 1'b0; e.f = f; e.a = a; e.ok = 1'b0; e.err = 1'b0; e.req = req;
        q.push_back(e);
    endtask

    task automatic push_fr(int at, logic ok, logic err, string req);
        exp_t e;
        e.at = at; e.is_frame = 1'b1; e.f = '0; e.a = 1'b0; e.ok = ok; e.err = err; e.req = req;
        q.push_back(e);
    endtask

    task automatic read_clear();
        flag_rd = 1'b1;
        tick(1);
        flag_rd = 1'b0;
        tick(2);
    endtask

    task automatic spi_frame(int nbits, bit good, string req);
        int e;
        spi_cs_n = 1'b0;
        tick(2);
        for (int b = 0; b < nbits; b++) begin
            spi_sclk = 1'b1;
            tick(2);
            spi_sclk = 1'b0;
            tick(1);
        end
        spi_cs_n = 1'b1;
        e = cyc;
        push_fr(e + 1, good, !good, req);
        push_fr(e + 2, 1'b0, 1'b0, req);
        tick(4);
    endtask

    initial begin
        int c;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        push_fa(cyc, 8'h00, 1'b0, "reset");
        push_fr(cyc, 1'b0, 1'b0, "reset");
        tick(2);

        // R2 / R6: enabled ADC check flag, latched alert
        alert_en = 8'h02; dyn_mode = 1'b0;
        det_src = 8'h02; c = cyc;
        push_fa(c + 1, 8'h02, 1'b0, "R2");
        push_fa(c + 2, 8'h02, 1'b1, "R6");
        tick(1);
        det_src = 8'h00;
        tick(3);
        push_fa(cyc, 8'h02, 1'b1, "R2");

        // R3: read shows old value then clears; latched alert drops a cycle later
        flag_rd = 1'b1; c = cyc;
        push_fa(c, 8'h02, 1'b1, "R3");
        tick(1);
        flag_rd = 1'b0;
        push_fa(c + 1, 8'h00, 1'b1, "R6");
        push_fa(c + 2, 8'h00, 1'b0, "R6");
        tick(3);

        // R5: disabled FET failure latches without an alert
        det_src = 8'h40; c = cyc;
        push_fa(c + 1, 8'h40, 1'b0, "R5");
        push_fa(c + 2, 8'h40, 1'b0, "R5");
        tick(1);
        det_src = 8'h00;
        tick(3);
        push_fa(cyc, 8'h40, 1'b0, "R2");
        read_clear();
        push_fa(cyc, 8'h00, 1'b0, "R3");

        // R1: bits 0 and 3 of det_src are ignored
        alert_en = 8'hFF;
        det_src = 8'h09; c = cyc;
        push_fa(c + 1, 8'h00, 1'b0, "R1");
        push_fa(c + 2, 8'h00, 1'b0, "R1");
        tick(1);
        det_src = 8'h00;
        tick(3);

        // R1: every external source lands in its own bit
        alert_en = 8'h04;
        det_src = 8'hF6; c = cyc;
        push_fa(c + 1, 8'hF6, 1'b0, "R1");
        push_fa(c + 2, 8'hF6, 1'b1, "R1");
        tick(1);
        det_src = 8'h00;
        tick(2);
        read_clear();
        push_fa(cyc, 8'h00, 1'b0, "R3");

        // R4: persistent fault and a new pulse in the read cycle both survive
        alert_en = 8'h10;
        det_src = 8'h10;
        tick(3);
        det_src = 8'h30; flag_rd = 1'b1; c = cyc;
        push_fa(c, 8'h10, 1'b1, "R4");
        tick(1);
        flag_rd = 1'b0; det_src = 8'h10;
        push_fa(c + 1, 8'h30, 1'b1, "R4");
        tick(1);
        det_src = 8'h00;
        tick(2);
        push_fa(cyc, 8'h30, 1'b1, "R4");
        read_clear();
        push_fa(cyc, 8'h00, 1'b0, "R3");

        // R7: dynamic alert follows the live condition, flag stays
        dyn_mode = 1'b1; alert_en = 8'h80;
        det_src = 8'h80; c = cyc;
        push_fa(c + 2, 8'h80, 1'b1, "R7");
        tick(3);
        det_src = 8'h00;
        push_fa(c + 4, 8'h80, 1'b1, "R7");
        push_fa(c + 5, 8'h80, 1'b0, "R7");
        tick(4);
        read_clear();
        dyn_mode = 1'b0;

        // R8 / R9: frame length judgement
        alert_en = 8'h08;
        spi_frame(16, 1'b1, "R9");
        push_fa(cyc, 8'h00, 1'b0, "R9");
        spi_frame(15, 1'b0, "R8");
        push_fa(cyc, 8'h08, 1'b1, "R8");
        read_clear();
        spi_frame(32, 1'b1, "R9");
        spi_frame(0, 1'b1, "R9");
        push_fa(cyc, 8'h00, 1'b0, "R9");
        spi_frame(17, 1'b0, "R8");
        push_fa(cyc, 8'h08, 1'b1, "R8");
        read_clear();

        // R10: no carry between frames, clocks with select high ignored
        spi_frame(8, 1'b0, "R10");
        spi_frame(8, 1'b0, "R10");
        read_clear();
        for (int k = 0; k < 3; k++) begin
            spi_sclk = 1'b1;
            tick(2);
            spi_sclk = 1'b0;
            tick(1);
        end
        spi_frame(16, 1'b1, "R10");
        push_fa(cyc, 8'h00, 1'b0, "R10");

        tick(3);
        while (q.size() != 0) tick(1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule